// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns the decoded fields of a load or store into the address that goes out on the memory bus. It also produces the new value for the base register when the access updates that register. It takes the base register value and builds an offset from one of three sources: a zero-extended immediate, an index register, or the index register shifted left by a 5-bit amount. The offset is either added to or subtracted from the base.

One of three indexing modes selects the outputs. In offset mode the adjusted address drives the bus and the base is left unchanged. In pre-indexed mode the adjusted address drives the bus and is also written back to the base. In post-indexed mode the bus sees the unmodified base, and the adjusted value is written back. All arithmetic wraps modulo 2^ADDR_W.

The outputs are registered, so results appear one clock after the request. A strobe flags each result, and a write-back enable tells the register file when to store the write-back value.

Top module: `lsagu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs go to zero on that edge.
- R2: `out_valid_o` is high in the cycle after a clock edge that sampled `in_valid` high, and low in the cycle after an edge that sampled it low.
- R3: Mode 2'b00 (offset): `ea_o` = base ± offset, and `wb_en_o` is 0.
- R4: Mode 2'b01 (pre-indexed): `ea_o` and `wb_data_o` are both base ± offset, and `wb_en_o` is 1.
- R5: Mode 2'b10 (post-indexed): `ea_o` is the unmodified base, `wb_data_o` = base ± offset, and `wb_en_o` is 1.
- R6: Mode 2'b11 behaves exactly like offset mode, with no write-back.
- R7: Source select 2'b00 uses `imm_i` unchanged as the offset.
- R8: Source selects 2'b01 and 2'b11 use `index_i` unshifted as the offset.
- R9: Source select 2'b10 uses `index_i << shamt_i` for shift amounts 0 to 31. Bits shifted past bit 31 are discarded.
- R10: `sub_i` = 0 adds the offset and `sub_i` = 1 subtracts it. Both wrap modulo 2^32 across 0x00000000 and 0xFFFFFFFF.
- R11: `wb_en_o` is never high without `out_valid_o`. After a cycle with `in_valid` low, `ea_o` and `wb_data_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for the decoded fields |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| imm_i | input | 32 | Zero-extended immediate offset |
| shamt_i | input | 5 | Left shift amount for the index |
| src_sel_i | input | 2 | Offset source: 00 imm, 01/11 index, 10 shifted index |
| sub_i | input | 1 | 1 subtracts the offset, 0 adds it |
| mode_i | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 as offset |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| ea_o | output | 32 | Effective address |
| wb_data_o | output | 32 | Base write-back value |
| wb_en_o | output | 1 | Base write-back enable |

## Verification
The bench builds the block with its default parameters: ADDR_W = 32, which gives a 5-bit shift amount. With this width, real 32-bit wrap-around can be reached at both 0x00000000 and 0xFFFFFFFF. So can the full shift range, including amounts 0 and 31, where high index bits fall off. Directed vectors cover every mode, source and direction at these corners. Pseudorandom vectors, fed back to back, also exercise the one-cycle pipeline under continuous load.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_ALT    = 2'b11
  } idx_mode_e;

  typedef enum logic [1:0] {
    OPS_IMM   = 2'b00,
    OPS_REG   = 2'b01,
    OPS_SHREG = 2'b10,
    OPS_REG2  = 2'b11
  } ofs_src_e;
endpackage

// File: rtl/lsagu_operand.sv
module lsagu_operand
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SH_W   = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] index_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  ofs_src_e          src_i,
  output logic [ADDR_W-1:0] offset_o
);
  logic [ADDR_W-1:0] shifted;

  // Barrier shifter built stage by stage; bits pushed past the top are dropped.
  logic [ADDR_W-1:0] stage [SH_W+1];
  assign stage[0] = index_i;
  for (genvar s = 0; s < SH_W; s++) begin : g_shift
    assign stage[s+1] = shamt_i[s] ? (stage[s] << (1 << s)) : stage[s];
  end
  assign shifted = stage[SH_W];

  always_comb begin
    unique case (src_i)
      OPS_IMM:   offset_o = imm_i;
      OPS_SHREG: offset_o = shifted;
      default:   offset_o = index_i;
    endcase
  end
endmodule

// File: rtl/lsagu_addsub.sv
module lsagu_addsub #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic              sub_i,
  output logic [ADDR_W-1:0] sum_o
);
  // One carry chain: subtraction as base + ~offset + 1, carry-out dropped.
  logic [ADDR_W-1:0] opnd;
  logic [ADDR_W:0]   full;
  assign opnd  = sub_i ? ~offset_i : offset_i;
  assign full  = {1'b0, base_i} + {1'b0, opnd} + {{ADDR_W{1'b0}}, sub_i};
  assign sum_o = full[ADDR_W-1:0];
endmodule

// File: rtl/lsagu_route.sv
module lsagu_route
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] adj_i,
  input  idx_mode_e         mode_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] wb_o,
  output logic              wb_en_o
);
  always_comb begin
    wb_o = adj_i;
    unique case (mode_i)
      IDX_PRE: begin
        ea_o    = adj_i;
        wb_en_o = 1'b1;
      end
      IDX_POST: begin
        ea_o    = base_i;
        wb_en_o = 1'b1;
      end
      default: begin
        ea_o    = adj_i;
        wb_en_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SH_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [1:0]        src_sel_i,
  input  logic              sub_i,
  input  logic [1:0]        mode_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] wb_data_o,
  output logic              wb_en_o
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] adj;
  logic [ADDR_W-1:0] ea_d;
  logic [ADDR_W-1:0] wb_d;
  logic              wb_en_d;

  lsagu_operand #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_operand (
    .index_i  (index_i),
    .imm_i    (imm_i),
    .shamt_i  (shamt_i),
    .src_i    (ofs_src_e'(src_sel_i)),
    .offset_o (offset)
  );

  lsagu_addsub #(.ADDR_W(ADDR_W)) u_addsub (
    .base_i   (base_i),
    .offset_i (offset),
    .sub_i    (sub_i),
    .sum_o    (adj)
  );

  lsagu_route #(.ADDR_W(ADDR_W)) u_route (
    .base_i  (base_i),
    .adj_i   (adj),
    .mode_i  (idx_mode_e'(mode_i)),
    .ea_o    (ea_d),
    .wb_o    (wb_d),
    .wb_en_o (wb_en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      wb_en_o     <= 1'b0;
      ea_o        <= '0;
      wb_data_o   <= '0;
    end else begin
      out_valid_o <= in_valid;
      wb_en_o     <= in_valid & wb_en_d;
      if (in_valid) begin
        ea_o      <= ea_d;
        wb_data_o <= wb_d;
      end
    end
  end
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] base_i,
  input logic [1:0]        mode_i,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic [ADDR_W-1:0] wb_data_o,
  input logic              wb_en_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid_o); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid_o); // R2
  AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode_i == 2'b00 || mode_i == 2'b11)) |=> !wb_en_o); // R6
  AST_PRE_SAME: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_i == 2'b01) |=> (ea_o == wb_data_o) && wb_en_o); // R4
  AST_POST_BASE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_i == 2'b10) |=> (ea_o == $past(base_i)) && wb_en_o); // R5
  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> out_valid_o); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ea_o) && $stable(wb_data_o)); // R11
endmodule

bind lsagu_top lsagu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .base_i      (base_i),
  .mode_i      (mode_i),
  .out_valid_o (out_valid_o),
  .ea_o        (ea_o),
  .wb_data_o   (wb_data_o),
  .wb_en_o     (wb_en_o)
);

// File: tb/sim_lsagu_top.sv
module sim_lsagu_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct {
    logic [AW-1:0] ea;
    logic [AW-1:0] wb;
    logic          wb_en;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] base_i = '0, index_i = '0, imm_i = '0;
  logic [4:0]    shamt_i = '0;
  logic [1:0]    src_sel_i = '0, mode_i = '0;
  logic          sub_i = 1'b0;
  logic          out_valid_o, wb_en_o;
  logic [AW-1:0] ea_o, wb_data_o;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];
  logic [AW-1:0] last_ea = '0, last_wb = '0;
  bit monitor_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsagu_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_i(base_i),
    .index_i(index_i), .imm_i(imm_i), .shamt_i(shamt_i),
    .src_sel_i(src_sel_i), .sub_i(sub_i), .mode_i(mode_i),
    .out_valid_o(out_valid_o), .ea_o(ea_o), .wb_data_o(wb_data_o),
    .wb_en_o(wb_en_o)
  );

  task automatic check(input string tag, input bit ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, got, exp);
    end
  endtask

  // Independent reference model built from the requirement text
  function automatic exp_t model(input logic [AW-1:0] b, input logic [AW-1:0] x,
                                 input logic [AW-1:0] im, input logic [4:0] sh,
                                 input logic [1:0] src, input logic sb_sub,
                                 input logic [1:0] md, input string tag);
    exp_t e;
    logic [AW-1:0] off, adj;
    longint unsigned tmp;
    case (src)
      2'b00: off = im;
      2'b10: begin tmp = longint'(x) * (64'd1 << sh); off = tmp[AW-1:0]; end
      default: off = x;
    endcase
    if (sb_sub) tmp = (64'h1_0000_0000 + longint'(b) - longint'(off));
    else        tmp = longint'(b) + longint'(off);
    adj = tmp[AW-1:0];
    e.wb = adj;
    e.tag = tag;
    case (md)
      2'b01: begin e.ea = adj; e.wb_en = 1'b1; end
      2'b10: begin e.ea = b;   e.wb_en = 1'b1; end
      default: begin e.ea = adj; e.wb_en = 1'b0; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [AW-1:0] b, input logic [AW-1:0] x,
                       input logic [AW-1:0] im, input logic [4:0] sh,
                       input logic [1:0] src, input logic s,
                       input logic [1:0] md, input string tag);
    @(negedge clk);
    base_i = b; index_i = x; imm_i = im; shamt_i = sh;
    src_sel_i = src; sub_i = s; mode_i = md; in_valid = 1'b1;
    sb.push_back(model(b, x, im, sh, src, s, md, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      base_i = 32'hDEAD_BEEF; imm_i = 32'h1234_5678;
    end
  endtask

  // Monitor: pops one expected item per result strobe
  always @(negedge clk) begin
    if (monitor_on) begin
      if (out_valid_o) begin
        if (sb.size() == 0) begin
          check("R2", 1'b0, "unexpected valid", "no result");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, ea_o == e.ea && wb_data_o == e.wb && wb_en_o == e.wb_en,
                $sformatf("ea=%h wb=%h en=%0b", ea_o, wb_data_o, wb_en_o),
                $sformatf("ea=%h wb=%h en=%0b", e.ea, e.wb, e.wb_en));
          last_ea = e.ea;
          last_wb = e.wb;
        end
      end else if (wb_en_o) begin
        check("R11", 1'b0, "wb_en=1", "wb_en=0 without valid");
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 1'b0, "timeout", "completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", out_valid_o == 0 && wb_en_o == 0 && ea_o == 0 && wb_data_o == 0,
          $sformatf("v=%0b en=%0b ea=%h wb=%h", out_valid_o, wb_en_o, ea_o, wb_data_o),
          "all zero");
    rst = 1'b0;
    monitor_on = 1'b1;

    // Modes with immediate, both directions
    drive(32'h0000_1000, 32'h0, 32'h0000_0010, 5'd0, 2'b00, 1'b0, 2'b00, "R3_offset_add");
    drive(32'h0000_1000, 32'h0, 32'h0000_0010, 5'd0, 2'b00, 1'b1, 2'b00, "R3_offset_sub");
    drive(32'h0000_2000, 32'h0, 32'h0000_0040, 5'd0, 2'b00, 1'b0, 2'b01, "R4_pre_add");
    drive(32'h0000_2000, 32'h0, 32'h0000_0040, 5'd0, 2'b00, 1'b1, 2'b01, "R4_pre_sub");
    drive(32'h0000_3000, 32'h0, 32'h0000_0004, 5'd0, 2'b00, 1'b0, 2'b10, "R5_post_add");
    drive(32'h0000_3000, 32'h0, 32'h0000_0004, 5'd0, 2'b00, 1'b1, 2'b10, "R5_post_sub");
    drive(32'h0000_4000, 32'h0, 32'h0000_0100, 5'd0, 2'b00, 1'b0, 2'b11, "R6_mode3");
    // Sources
    drive(32'h1000_0000, 32'hAAAA_0000, 32'h0000_0008, 5'd7, 2'b00, 1'b0, 2'b01, "R7_imm");
    drive(32'h1000_0000, 32'h0000_0123, 32'hFFFF_FFFF, 5'd3, 2'b01, 1'b0, 2'b01, "R8_reg");
    drive(32'h1000_0000, 32'h0000_0123, 32'hFFFF_FFFF, 5'd3, 2'b11, 1'b1, 2'b00, "R8_reg_alt");
    drive(32'h1000_0000, 32'h0000_0123, 32'h0, 5'd0,  2'b10, 1'b0, 2'b01, "R9_shift0");
    drive(32'h1000_0000, 32'h0000_0003, 32'h0, 5'd31, 2'b10, 1'b0, 2'b01, "R9_shift31");
    drive(32'h1000_0000, 32'h0000_0005, 32'h0, 5'd2,  2'b10, 1'b1, 2'b10, "R9_shift2_sub");
    // Wrap-around corners
    drive(32'hFFFF_FFFF, 32'h0, 32'h0000_0001, 5'd0, 2'b00, 1'b0, 2'b01, "R10_wrap_top");
    drive(32'h0000_0000, 32'h0, 32'h0000_0001, 5'd0, 2'b00, 1'b1, 2'b01, "R10_wrap_zero");
    drive(32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 5'd0, 2'b01, 1'b0, 2'b10, "R10_wrap_post");
    drive(32'h0000_0008, 32'h8000_0001, 32'h0, 5'd31, 2'b10, 1'b1, 2'b00, "R10_wrap_shift");
    // Idle: strobes drop, values hold
    idle(3);
    @(negedge clk);
    check("R2", out_valid_o == 1'b0, $sformatf("%0b", out_valid_o), "0");
    check("R11", ea_o == last_ea && wb_data_o == last_wb && wb_en_o == 1'b0,
          $sformatf("ea=%h wb=%h en=%0b", ea_o, wb_data_o, wb_en_o),
          $sformatf("ea=%h wb=%h en=0", last_ea, last_wb));
    // Pseudorandom back-to-back stream
    for (int i = 0; i < 200; i++) begin
      drive($urandom(), $urandom(), $urandom(), 5'($urandom()), 2'($urandom()),
            1'($urandom()), 2'($urandom()), "R10_random");
    end
    idle(3);
    check("R2", sb.size() == 0, $sformatf("%0d pending", sb.size()), "0 pending");
    // Reset mid-stream clears outputs
    drive(32'h0000_5000, 32'h0, 32'h4, 5'd0, 2'b00, 1'b0, 2'b01, "R4_pre_add2");
    idle(1);
    monitor_on = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1", out_valid_o == 0 && wb_en_o == 0 && ea_o == 0 && wb_data_o == 0,
          $sformatf("v=%0b en=%0b ea=%h wb=%h", out_valid_o, wb_en_o, ea_o, wb_data_o),
          "all zero");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule